// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the register side of a simple 8-data-bit, 1-stop-bit serial port. A bus slave port reaches four 32-bit words. The block turns accesses to them into push and pop strobes for a small transmit FIFO and a small receive FIFO. It keeps per-cause interrupt flags and drives one host interrupt line. The bit shifter and the baud-rate generator sit outside the block. The shifter takes characters from the transmit FIFO, reports whether it is still shifting, and delivers each received character with a one-cycle strobe.

Characters move through handshake bits inside the data word itself. To send, software writes a character together with the transmit handshake bit. To consume a received character, software writes 1 to the receive handshake bit. Interrupt causes are write-one-to-clear. Software sees the pending set as the status word ANDed with the enable word, and a summary bit in the control word shows when any enabled cause is pending.

Top module: `hsk_uart_regs`

## Requirements
- R1: After reset, the control, interrupt-status and interrupt-enable words read 0, and the data word reads 0x200 (transmit handshake bit 9 = 1, receive handshake bit 8 = 0). `irq` is 0, `tx_valid` is 0 and `port_en` is 0.
- R2: Writing word 0x0 with bit 9 set pushes bits [7:0] into the transmit FIFO. Characters appear on `tx_data` in write order while `tx_valid` is 1, and each cycle with `tx_take` high removes one character.
- R3: With DEPTH characters queued, the data word reads bit 9 as 0, and a further push is ignored. The queued characters are left unchanged.
- R4: Each cycle with `rx_strobe` high stores `rx_char`. The data word then reads bit 8 as 1 with the oldest character in [7:0]. Writing word 0x0 with bit 8 set removes that character. A removal from an empty receive FIFO is ignored.
- R5: In word 0x8, bit 0 (receive-valid) is set when a received character is accepted. Bit 1 (transmit-empty) is set when the last queued character is taken. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and a set in the same cycle wins over a clear.
- R6: Control bit 7 reads 1 exactly when (word 0x8 AND word 0xC) is nonzero. `irq` equals control bit 4 (host-interrupt enable) AND control bit 7.
- R7: Control bits [1:0] select parity on `parity_mode`: 0 none, 1 even, 2 odd. Code 3 drives 0 (none).
- R8: Control bit 5 drives `tx_break` for as long as it is set.
- R9: Control bit 6 (read-only) reads 1 while the transmit FIFO holds a character or `tx_shifting` is 1.
- R10: Control bits [3:2] = 0 disables the port. `port_en` is 0, `tx_valid` is held 0 while pushes still queue, and `rx_strobe` is ignored. Any nonzero value enables the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits [3:2] pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from current state |
| tx_data | output | 8 | Oldest queued transmit character |
| tx_valid | output | 1 | A transmit character is offered to the shifter |
| tx_take | input | 1 | Shifter takes the offered character |
| tx_shifting | input | 1 | Shifter is still sending |
| rx_char | input | 8 | Received character |
| rx_strobe | input | 1 | Received character valid for one cycle |
| parity_mode | output | 2 | 0 none, 1 even, 2 odd |
| tx_break | output | 1 | Hold the line in break |
| port_en | output | 1 | Port enabled |
| irq | output | 1 | Host interrupt |

## Verification
Assertions check on every cycle that the FIFO occupancy never exceeds its depth. They also check that an accepted push raises the occupancy by one, that a pop from an empty FIFO leaves it empty, that causes set on an accepted receive, and that a clear with no competing set drops the cause. Only the bench's scenarios can show the data order through each FIFO, the discarded fifth push, the decoding of the parity codes, the effect of disabling the port, and the combined gating of the host interrupt by its enable bit.

// File: rtl/hsk_uart_pkg.sv
package hsk_uart_pkg;
    localparam int WORD_W = 32;
    localparam int CHAR_W = 8;
    localparam int NCAUSE = 2;

    localparam logic [1:0] W_DATA = 2'd0;
    localparam logic [1:0] W_CTRL = 2'd1;
    localparam logic [1:0] W_IST  = 2'd2;
    localparam logic [1:0] W_IEN  = 2'd3;

    localparam int B_RXH = 8;
    localparam int B_TXH = 9;

    localparam int C_RX = 0;
    localparam int C_TX = 1;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2
    } parity_e;

    typedef struct packed {
        logic       brk;
        logic       host_en;
        logic [1:0] mode;
        logic [1:0] par;
    } ctrl_t;

    function automatic parity_e decode_par(input logic [1:0] code);
        case (code)
            2'd1:    return PAR_EVEN;
            2'd2:    return PAR_ODD;
            default: return PAR_NONE;
        endcase
    endfunction
endpackage

// File: rtl/hsk_fifo.sv
module hsk_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    rp, wp;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rp    <= '0;
            wp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= bump(wp);
            end
            if (do_pop) rp <= bump(rp);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    a_r2_push_grows: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=> count == $past(count) + 1'b1);
    a_r4_pop_empty_ignored: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty);
endmodule

// File: rtl/hsk_irq.sv
module hsk_irq
    import hsk_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NCAUSE-1:0] set_vec,
    input  logic              clr_wr,
    input  logic [NCAUSE-1:0] clr_mask,
    input  logic              en_wr,
    input  logic [NCAUSE-1:0] en_data,
    output logic [NCAUSE-1:0] status,
    output logic [NCAUSE-1:0] enable,
    output logic              summary
);
    logic [NCAUSE-1:0] clr_eff;
    assign clr_eff = clr_wr ? clr_mask : '0;
    assign summary = |(status & enable);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~clr_eff) | set_vec;
            if (en_wr) enable <= en_data;
        end
    end

    for (genvar i = 0; i < NCAUSE; i++) begin : g_chk
        a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> status[i]);
        a_r5_w1c: assert property (@(posedge clk) disable iff (rst)
            (clr_wr && clr_mask[i] && !set_vec[i]) |=> !status[i]);
    end
endmodule

// File: rtl/hsk_uart_regs.sv
module hsk_uart_regs
    import hsk_uart_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic [CHAR_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_take,
    input  logic              tx_shifting,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              rx_strobe,
    output logic [1:0]        parity_mode,
    output logic              tx_break,
    output logic              port_en,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH + 1);

    ctrl_t             ctrl;
    logic              wr_go;
    logic [1:0]        widx;
    logic              tx_push, tx_pop, tx_empty, tx_full;
    logic              rx_push, rx_pop, rx_empty, rx_full;
    logic [CW-1:0]     tx_cnt, rx_cnt;
    logic [CHAR_W-1:0] rx_head;
    logic              tx_busy, summary, drained;
    logic [NCAUSE-1:0] set_vec, ist, ien;

    assign widx  = bus_addr[3:2];
    assign wr_go = bus_sel && bus_wr;

    assign tx_push = wr_go && widx == W_DATA && bus_wdata[B_TXH];
    assign rx_pop  = wr_go && widx == W_DATA && bus_wdata[B_RXH];
    assign port_en = ctrl.mode != 2'd0;
    assign tx_pop  = tx_take && tx_valid;
    assign rx_push = rx_strobe && port_en;

    hsk_fifo #(.WIDTH(CHAR_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .din(bus_wdata[CHAR_W-1:0]),
        .pop(tx_pop), .head(tx_data), .empty(tx_empty), .full(tx_full),
        .count(tx_cnt));

    hsk_fifo #(.WIDTH(CHAR_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .din(rx_char),
        .pop(rx_pop), .head(rx_head), .empty(rx_empty), .full(rx_full),
        .count(rx_cnt));

    assign tx_valid = !tx_empty && port_en;
    assign drained  = tx_pop && tx_cnt == CW'(1) && !(tx_push && !tx_full);
    assign tx_busy  = !tx_empty || tx_shifting;

    always_comb begin
        set_vec       = '0;
        set_vec[C_RX] = rx_push && !rx_full;
        set_vec[C_TX] = drained;
    end

    hsk_irq u_irq (
        .clk(clk), .rst(rst), .set_vec(set_vec),
        .clr_wr(wr_go && widx == W_IST), .clr_mask(bus_wdata[NCAUSE-1:0]),
        .en_wr(wr_go && widx == W_IEN), .en_data(bus_wdata[NCAUSE-1:0]),
        .status(ist), .enable(ien), .summary(summary));

    always_ff @(posedge clk) begin
        if (rst) ctrl <= '0;
        else if (wr_go && widx == W_CTRL) ctrl <= ctrl_t'(bus_wdata[5:0]);
    end

    assign parity_mode = decode_par(ctrl.par);
    assign tx_break    = ctrl.brk;
    assign irq         = ctrl.host_en && summary;

    always_comb begin
        bus_rdata = '0;
        case (widx)
            W_DATA: begin
                bus_rdata[CHAR_W-1:0] = rx_empty ? '0 : rx_head;
                bus_rdata[B_RXH]      = !rx_empty;
                bus_rdata[B_TXH]      = !tx_full;
            end
            W_CTRL: bus_rdata[7:0] = {summary, tx_busy, ctrl};
            W_IST:  bus_rdata[NCAUSE-1:0] = ist;
            default: bus_rdata[NCAUSE-1:0] = ien;
        endcase
    end

    a_r10_rx_dropped: assert property (@(posedge clk) disable iff (rst)
        (!port_en && !rx_pop) |=> $stable(rx_cnt));
    a_r6_irq_needs_cause: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ist & ien) != '0);
endmodule

// File: tb/hsk_uart_regs_test.sv
module hsk_uart_regs_test;
    localparam int CLK_P = 10;
    localparam int DEPTH = 4;

    logic        clk = 0, rst = 1;
    logic        bus_sel = 0, bus_wr = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic [7:0]  tx_data, rx_char = 0;
    logic        tx_valid, tx_take = 0, tx_shifting = 0, rx_strobe = 0;
    logic [1:0]  parity_mode;
    logic        tx_break, port_en, irq;
    int          n_run = 0, n_fail = 0;
    logic [31:0] v;

    always #(CLK_P/2) clk = ~clk;

    hsk_uart_regs #(.DEPTH(DEPTH)) uut (.*);

    task automatic chk(input string req, input logic [31:0] act, exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata; bus_sel = 0;
    endtask

    task automatic take();
        @(negedge clk); tx_take = 1; @(negedge clk); tx_take = 0;
    endtask

    task automatic rx_in(input logic [7:0] c);
        @(negedge clk); rx_char = c; rx_strobe = 1; @(negedge clk); rx_strobe = 0;
    endtask

    task automatic t_reset();
        rd(4'h0, v); chk("R1 data", v, 32'h200);
        rd(4'h4, v); chk("R1 ctrl", v, 0);
        rd(4'h8, v); chk("R1 ist", v, 0);
        rd(4'hC, v); chk("R1 ien", v, 0);
        chk("R1 outs", {irq, tx_valid, port_en}, 0);
    endtask

    task automatic t_tx();
        wr(4'h4, 32'h4);
        wr(4'h0, 32'h241); wr(4'h0, 32'h242);
        #1 chk("R2 first", {tx_valid, tx_data}, 9'h141);
        rd(4'h4, v); chk("R9 busy fifo", v[6], 1);
        take(); #1 chk("R2 second", {tx_valid, tx_data}, 9'h142);
        rd(4'h8, v); chk("R5 not drained", v[1], 0);
        take(); #1 chk("R2 empty", tx_valid, 0);
        rd(4'h8, v); chk("R5 tx empty set", v[1], 1);
        rd(4'h4, v); chk("R9 idle", v[6], 0);
        tx_shifting = 1;
        rd(4'h4, v); chk("R9 shifting", v[6], 1);
        tx_shifting = 0;
        wr(4'h8, 32'h3);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH + 1; i++) wr(4'h0, 32'h210 + i);
        rd(4'h0, v); chk("R3 full handshake", v[9], 0);
        for (int i = 0; i < DEPTH; i++) begin
            #1 chk("R3 order", {tx_valid, tx_data}, {1'b1, 8'(8'h10 + i)});
            take();
        end
        #1 chk("R3 fifth dropped", tx_valid, 0);
        wr(4'h8, 32'h3);
    endtask

    task automatic t_rx();
        rx_in(8'h5A);
        rd(4'h0, v); chk("R4 present", v, 32'h35A);
        rd(4'h8, v); chk("R5 rx set", v[0], 1);
        wr(4'h0, 32'h100);
        rd(4'h0, v); chk("R4 popped", v[8], 0);
        wr(4'h0, 32'h100);
        rx_in(8'h77);
        rd(4'h0, v); chk("R4 empty pop ignored", v, 32'h377);
        wr(4'h0, 32'h100);
    endtask

    task automatic t_irq();
        wr(4'h8, 32'h0);
        rd(4'h8, v); chk("R5 write0 keeps", v[0], 1);
        wr(4'hC, 32'h1);
        rd(4'h4, v); chk("R6 summary", v[7], 1);
        #1 chk("R6 irq gated", irq, 0);
        wr(4'h4, 32'h14);
        #1 chk("R6 irq on", irq, 1);
        wr(4'hC, 32'h2);
        rd(4'h4, v); chk("R6 masked", {v[7], irq}, 0);
        wr(4'h8, 32'h1);
        rd(4'h8, v); chk("R5 w1c", v, 0);
    endtask

    task automatic t_ctrl();
        wr(4'h4, 32'h5); #1 chk("R7 even", parity_mode, 1);
        wr(4'h4, 32'h6); #1 chk("R7 odd", parity_mode, 2);
        wr(4'h4, 32'h7); #1 chk("R7 code3", parity_mode, 0);
        wr(4'h4, 32'h24); #1 chk("R8 break", tx_break, 1);
        wr(4'h4, 32'h4); #1 chk("R8 release", tx_break, 0);
    endtask

    task automatic t_disable();
        wr(4'h4, 32'h0);
        #1 chk("R10 port off", port_en, 0);
        wr(4'h0, 32'h2AB);
        #1 chk("R10 tx held", tx_valid, 0);
        rx_in(8'h11);
        rd(4'h0, v); chk("R10 rx ignored", v[8], 0);
        wr(4'h4, 32'h8);
        #1 chk("R10 reenabled", {port_en, tx_valid, tx_data}, 10'h3AB);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset(); t_tx(); t_full(); t_rx(); t_irq(); t_ctrl(); t_disable();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule